// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Sticky Timeout

This block is the front end for enhanced parallel port address and data cycles. It sits next to the printer port register file. A host access at offset 3 becomes an address cycle, and a host access at offset 4 becomes a data cycle. Each cycle goes out to a downstream peripheral port as one or more byte requests. The neighbouring control register decides whether a cycle may start at all. A write cycle needs one exact control pattern and a read cycle needs another. A cycle that does not match is dropped. A dropped write has no effect, and a dropped read returns all ones.

Data cycles may be 1, 2 or 4 bytes wide. A wide access is split into byte requests, lowest byte first. Read bytes are put back into their little-endian lanes. If the downstream port reports an error, the rest of the access is abandoned and a sticky timeout flag is set. The flag appears as bit 0 of every status read at offset 1. Software clears it by writing the status offset with bit 0 set. The host waits on a ready pulse that marks the end of each access.

Top module: `epp_cycle_gate`

## Requirements
- R1: A write at offset 3 or 4 starts downstream requests only when the control register ANDed with 0x2F equals 0x04. The mask covers direction bit 5, select bit 3, init bit 2, autolf bit 1 and strobe bit 0. With any other control value the write makes no downstream request and has no effect.
- R2: A read at offset 3 or 4 starts downstream requests only when the control register ANDed with 0x2F equals 0x24. Otherwise no request is made and the read data is all ones over the access width (0xFF, 0xFFFF or 0xFFFFFFFF), with zeros above it.
- R3: At offset 4, host_size codes 0, 1 and 2 mean 1, 2 and 4 bytes, and code 3 also means 4 bytes. The bytes go downstream lowest first. Write byte k is host_wdata[8k+7:8k], and read byte k is returned in host_rdata[8k+7:8k].
- R4: An offset-3 access is always one byte and has dn_addr_cyc = 1. Offset-4 requests have dn_addr_cyc = 0. dn_wr is 1 for writes and 0 for reads.
- R5: If dn_err is returned for a byte, no further bytes of that access are requested and the timeout flag is set. Read lanes that were not acknowledged stay 0xFF.
- R6: A read at offset 1 returns port_status in bits 7..1 and the timeout flag in bit 0, with zeros above bit 7.
- R7: A write at offset 1 with host_wdata[0] = 1 clears the timeout flag. A write with host_wdata[0] = 0 leaves the flag unchanged.
- R8: Reset clears the timeout flag, host_ready and dn_req.
- R9: host_ready is high for exactly one cycle when an access ends. Writes and accesses at offsets other than 1, 3 and 4 return zero data, and accesses at those other offsets end in the cycle after they are accepted.
- R10: Once dn_req is raised, it stays high with dn_wdata, dn_wr and dn_addr_cyc stable until dn_ack or dn_err is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Register offset |
| host_size | input | 2 | Access width code for offset 4 |
| host_wdata | input | 32 | Write data, little-endian lanes |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle end-of-access pulse |
| ctrl_reg | input | 8 | Current control register value |
| port_status | input | 7 | Status lines for bits 7..1 |
| dn_req | output | 1 | Downstream byte request |
| dn_wr | output | 1 | Downstream direction, 1 = write |
| dn_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| dn_wdata | output | 8 | Downstream write byte |
| dn_rdata | input | 8 | Downstream read byte, valid with dn_ack |
| dn_ack | input | 1 | Byte completed |
| dn_err | input | 1 | Byte failed |

## Verification
The assertions take the following for granted about the inputs:
- host_req stays high until host_ready.
- dn_ack and dn_err are never high together, and never high while dn_req is low.
- ctrl_reg does not change while an access is in flight.

The bench keeps within these rules in three ways. A single driver task holds the request until the ready pulse. The downstream responder answers only a raised request, with either an acknowledge or an error. The control value changes only between accesses. Errors are injected at chosen byte positions to check that the remaining bytes are abandoned.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam logic [2:0] OFF_STATUS = 3'd1;
  localparam logic [2:0] OFF_ADDR   = 3'd3;
  localparam logic [2:0] OFF_DATA   = 3'd4;
  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} seq_st_t;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
(
  input  logic [7:0] ctrl,
  output logic       wr_ok,
  output logic       rd_ok
);
  always_comb begin
    wr_ok = (ctrl & GATE_MASK) == GATE_WR;
    rd_ok = (ctrl & GATE_MASK) == GATE_RD;
  end
endmodule

// File: rtl/epp_tmo_flag.sv
module epp_tmo_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [2:0]        host_off,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_ready,
  input  logic [BYTE_W-1:1] port_status,
  input  logic              tmo_flag,
  input  logic              wr_ok,
  input  logic              rd_ok,
  output logic              tmo_set,
  output logic              tmo_clr,
  output logic              dn_req,
  output logic              dn_wr,
  output logic              dn_addr_cyc,
  output logic [BYTE_W-1:0] dn_wdata,
  input  logic [BYTE_W-1:0] dn_rdata,
  input  logic              dn_ack,
  input  logic              dn_err
);
  localparam int NB = HOST_W / BYTE_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  seq_st_t          st;
  logic [IW-1:0]    idx, last, nidx;
  logic [HOST_W-1:0] wbuf, rbuf, rbuf_nx;
  logic             wr_q;
  logic             acc_epp, acc_ok;
  logic [IW+1:0]    raw_nb;
  logic [IW:0]      acc_nb, acc_last;

  function automatic logic [HOST_W-1:0] lane_ones(input logic [IW:0] n);
    logic [HOST_W-1:0] r;
    r = '0;
    for (int k = 0; k < NB; k++)
      if (k < int'(n)) r[k*BYTE_W +: BYTE_W] = '1;
    return r;
  endfunction

  always_comb begin
    acc_epp  = (host_off == OFF_ADDR) || (host_off == OFF_DATA);
    acc_ok   = host_wr ? wr_ok : rd_ok;
    raw_nb   = (IW+2)'(1) << host_size;
    if (host_off == OFF_ADDR)      acc_nb = (IW+1)'(1);
    else if (raw_nb > (IW+2)'(NB)) acc_nb = (IW+1)'(NB);
    else                           acc_nb = raw_nb[IW:0];
    acc_last = acc_nb - (IW+1)'(1);
    nidx     = idx + IW'(1);
    tmo_set  = (st == ST_XFER) && dn_req && dn_err;
    tmo_clr  = (st == ST_IDLE) && host_req && host_wr &&
               (host_off == OFF_STATUS) && host_wdata[0];
    rbuf_nx  = rbuf;
    if (dn_ack && !dn_err && !wr_q) rbuf_nx[idx*BYTE_W +: BYTE_W] = dn_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; host_ready <= 1'b0; host_rdata <= '0;
      dn_req <= 1'b0; dn_wr <= 1'b0; dn_addr_cyc <= 1'b0; dn_wdata <= '0;
      idx <= '0; last <= '0; wbuf <= '0; rbuf <= '0; wr_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          host_ready <= 1'b0;
          if (host_req) begin
            if (acc_epp && acc_ok) begin
              st          <= ST_XFER;
              dn_req      <= 1'b1;
              dn_wr       <= host_wr;
              dn_addr_cyc <= (host_off == OFF_ADDR);
              dn_wdata    <= host_wdata[BYTE_W-1:0];
              wbuf        <= host_wdata;
              rbuf        <= lane_ones(acc_nb);
              idx         <= '0;
              last        <= acc_last[IW-1:0];
              wr_q        <= host_wr;
            end else begin
              st         <= ST_DONE;
              host_ready <= 1'b1;
              if (acc_epp)
                host_rdata <= host_wr ? '0 : lane_ones(acc_nb);
              else if (host_off == OFF_STATUS && !host_wr)
                host_rdata <= {{(HOST_W-BYTE_W){1'b0}}, port_status, tmo_flag};
              else
                host_rdata <= '0;
            end
          end
        end
        ST_XFER: begin
          if (dn_ack || dn_err) begin
            rbuf <= rbuf_nx;
            if (dn_err || idx == last) begin
              dn_req     <= 1'b0;
              st         <= ST_DONE;
              host_ready <= 1'b1;
              host_rdata <= wr_q ? '0 : rbuf_nx;
            end else begin
              idx      <= nidx;
              dn_wdata <= wbuf[nidx*BYTE_W +: BYTE_W];
            end
          end
        end
        default: begin
          host_ready <= 1'b0;
          st         <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate #(
  parameter int HOST_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [2:0]        host_off,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_ready,
  input  logic [7:0]        ctrl_reg,
  input  logic [BYTE_W-1:1] port_status,
  output logic              dn_req,
  output logic              dn_wr,
  output logic              dn_addr_cyc,
  output logic [BYTE_W-1:0] dn_wdata,
  input  logic [BYTE_W-1:0] dn_rdata,
  input  logic              dn_ack,
  input  logic              dn_err
);
  logic wr_ok, rd_ok, tmo_set, tmo_clr, tmo_q;

  epp_gate i_gate (.ctrl(ctrl_reg), .wr_ok(wr_ok), .rd_ok(rd_ok));

  epp_tmo_flag i_tmo (.clk(clk), .rst(rst), .set(tmo_set), .clr(tmo_clr), .flag(tmo_q));

  epp_byte_seq #(.HOST_W(HOST_W), .BYTE_W(BYTE_W)) i_seq (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_wr(host_wr), .host_off(host_off),
    .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready),
    .port_status(port_status), .tmo_flag(tmo_q),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .tmo_set(tmo_set), .tmo_clr(tmo_clr),
    .dn_req(dn_req), .dn_wr(dn_wr), .dn_addr_cyc(dn_addr_cyc),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack), .dn_err(dn_err)
  );
endmodule

// File: rtl/epp_cycle_gate_chk.sv
module epp_cycle_gate_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ready,
  input logic [7:0]        ctrl_reg,
  input logic              dn_req,
  input logic              dn_wr,
  input logic              dn_addr_cyc,
  input logic [BYTE_W-1:0] dn_wdata,
  input logic              dn_ack,
  input logic              dn_err,
  input logic              tmo_flag
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_ack && !dn_err |=>
      dn_req && $stable(dn_wdata) && $stable(dn_wr) && $stable(dn_addr_cyc));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  // R5
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req && dn_err |=> !dn_req && tmo_flag);

  // R1
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) && dn_wr |-> (($past(ctrl_reg) & 8'h2F) == 8'h04));

  // R2
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) && !dn_wr |-> (($past(ctrl_reg) & 8'h2F) == 8'h24));
endmodule

bind epp_cycle_gate epp_cycle_gate_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .ctrl_reg(ctrl_reg),
  .dn_req(dn_req), .dn_wr(dn_wr), .dn_addr_cyc(dn_addr_cyc),
  .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err), .tmo_flag(tmo_q)
);

// File: tb/test_epp_cycle_gate.sv
module test_epp_cycle_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        host_ready;
  logic [7:0]  ctrl = 8'h00;
  logic [7:1]  stat_in = 7'h5C;
  logic        dn_req, dn_wr, dn_addr_cyc;
  logic [7:0]  dn_wdata, dn_rdata = '0;
  logic        dn_ack = 1'b0, dn_err = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;
  logic model_tmo = 1'b0;
  logic [31:0] hq[$];
  string       htag[$];
  logic [9:0]  dq[$];
  string       dtag[$];
  int wcnt = 0, bcnt = 0, err_at = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  epp_cycle_gate i_epp_cycle_gate (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready), .ctrl_reg(ctrl),
    .port_status(stat_in), .dn_req(dn_req), .dn_wr(dn_wr),
    .dn_addr_cyc(dn_addr_cyc), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .dn_ack(dn_ack), .dn_err(dn_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // downstream responder and transfer monitor
  always @(negedge clk) begin
    dn_ack = 1'b0;
    dn_err = 1'b0;
    if (rst) wcnt = 0;
    else if (dn_req) begin
      if (wcnt >= 1) begin
        if (dq.size() == 0)
          check(0, "R1 R2 unexpected transfer", {22'b0, dn_addr_cyc, dn_wr, dn_wdata}, 32'h0);
        else begin
          logic [9:0] e;
          string t;
          e = dq.pop_front();
          t = dtag.pop_front();
          check(dn_addr_cyc == e[9] && dn_wr == e[8] && (!e[8] || dn_wdata == e[7:0]),
                t, {22'b0, dn_addr_cyc, dn_wr, dn_wdata}, {22'b0, e});
        end
        if (bcnt == err_at) dn_err = 1'b1;
        else begin
          dn_ack = 1'b1;
          dn_rdata = 8'hA0 + bcnt[7:0];
        end
        bcnt++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  // host result monitor
  always @(negedge clk) begin
    if (!rst && host_ready) begin
      if (hq.size() == 0) check(0, "R9 unexpected ready", host_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = hq.pop_front();
        t = htag.pop_front();
        check(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  task automatic access(input logic [2:0] off, input logic wr, input logic [1:0] sz,
                        input logic [31:0] wd, input int errb, input string tag);
    int n;
    logic ok;
    logic [31:0] exp;
    exp = '0;
    if (off == 3'd3 || off == 3'd4) begin
      n = (off == 3'd3) ? 1 : (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      ok = wr ? ((ctrl & 8'h2F) == 8'h04) : ((ctrl & 8'h2F) == 8'h24);
      if (!wr) for (int k = 0; k < n; k++) exp[k*8 +: 8] = 8'hFF;
      if (ok) begin
        for (int k = 0; k < n; k++) begin
          if (errb >= 0 && k > errb) break;
          dq.push_back({off == 3'd3, wr, wd[k*8 +: 8]});
          dtag.push_back(tag);
          if (k == errb) model_tmo = 1'b1;
          else if (!wr) exp[k*8 +: 8] = 8'hA0 + 8'(k);
        end
      end
    end else if (off == 3'd1 && !wr) exp = {24'b0, stat_in, model_tmo};
    hq.push_back(exp);
    htag.push_back(tag);
    if (off == 3'd1 && wr && wd[0]) model_tmo = 1'b0;
    bcnt = 0;
    err_at = errb;
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_off = off; host_size = sz; host_wdata = wd;
    do @(negedge clk); while (!host_ready);
    host_req = 1'b0;
    @(negedge clk);
    check(!host_ready, "R9 ready one cycle", {31'b0, host_ready}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(!host_ready && !dn_req, "R8 reset outputs", {30'b0, host_ready, dn_req}, 32'h0);
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R8 R6 status after reset");
    // writes, gate open (R1 R3 R4)
    ctrl = 8'h04;
    access(3'd3, 1'b1, 2'd2, 32'h0000005A, -1, "R4 address write");
    access(3'd4, 1'b1, 2'd0, 32'h00000011, -1, "R3 data write 1B");
    access(3'd4, 1'b1, 2'd1, 32'h00002233, -1, "R3 data write 2B");
    access(3'd4, 1'b1, 2'd2, 32'hCAFEBABE, -1, "R3 data write 4B");
    ctrl = 8'hC4;
    access(3'd4, 1'b1, 2'd1, 32'h00007788, -1, "R1 unmasked bits ignored");
    // reads, gate open (R2 R3 R4)
    ctrl = 8'h24;
    access(3'd3, 1'b0, 2'd2, 32'h0, -1, "R4 address read");
    access(3'd4, 1'b0, 2'd0, 32'h0, -1, "R3 data read 1B");
    access(3'd4, 1'b0, 2'd1, 32'h0, -1, "R3 data read 2B");
    access(3'd4, 1'b0, 2'd2, 32'h0, -1, "R3 data read 4B");
    access(3'd4, 1'b0, 2'd3, 32'h0, -1, "R3 size code 3");
    // gate closed
    ctrl = 8'h05;
    access(3'd4, 1'b1, 2'd2, 32'h12345678, -1, "R1 write dropped strobe");
    ctrl = 8'h0C;
    access(3'd3, 1'b1, 2'd0, 32'h000000AA, -1, "R1 write dropped select");
    ctrl = 8'h24;
    access(3'd4, 1'b1, 2'd0, 32'h000000AA, -1, "R1 write dropped dir");
    ctrl = 8'h04;
    access(3'd4, 1'b0, 2'd1, 32'h0, -1, "R2 read blocked 2B");
    ctrl = 8'h26;
    access(3'd4, 1'b0, 2'd2, 32'h0, -1, "R2 read blocked 4B");
    access(3'd3, 1'b0, 2'd0, 32'h0, -1, "R2 read blocked addr");
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R6 flag still clear");
    // errors and flag handling
    ctrl = 8'h04;
    access(3'd4, 1'b1, 2'd2, 32'h44332211, 1, "R5 write error byte 1");
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R6 flag set");
    access(3'd1, 1'b1, 2'd0, 32'h000000FE, -1, "R7 write bit0 zero");
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R7 flag kept");
    access(3'd1, 1'b1, 2'd0, 32'h00000001, -1, "R7 write bit0 one");
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R7 flag cleared");
    ctrl = 8'h24;
    access(3'd4, 1'b0, 2'd2, 32'h0, 2, "R5 read error byte 2");
    stat_in = 7'h2B;
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R6 status merge");
    access(3'd1, 1'b1, 2'd0, 32'h00000001, -1, "R7 clear");
    access(3'd3, 1'b0, 2'd0, 32'h0, 0, "R5 address read error");
    access(3'd0, 1'b0, 2'd0, 32'h0, -1, "R9 other offset");
    // reset clears the flag
    @(negedge clk); rst = 1'b1;
    model_tmo = 1'b0;
    repeat (2) @(negedge clk); rst = 1'b0;
    access(3'd1, 1'b0, 2'd0, 32'h0, -1, "R8 flag cleared by reset");
    repeat (3) @(negedge clk);
    check(dq.size() == 0 && hq.size() == 0, "R1 R9 queues drained",
          32'(dq.size() + hq.size()), 32'h0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule